// File: doc/BRIEF.md
# Multi-Lane SPI Master Sequencer

This block is a byte-oriented SPI master whose data path can be one, two or four lanes wide. Software-side logic pushes bytes into a small transmit buffer; each buffered byte carries a copy of the lane mode that was in force when it was pushed and a flag that marks the end of a message. A sequencer pops entries one at a time. It drives the serial clock and the frame select, and it shifts the byte out, or samples a byte in, with the lane width and direction that the entry's tag names. Timing is fixed to clock polarity 0 and phase 0, and one serial clock spans two system clocks.

The mode register accepts a write only when the requested transition is allowed and, for moves into or out of legacy mode, only when the transmit buffer is empty. A rejected write leaves the mode unchanged and sets a sticky error flag, which is cleared by a one-cycle pulse. For read modes the caller still pushes one dummy byte per byte to be read; the dummy sets the length of the read, and all lanes are released while it runs. Frame select normally goes inactive for at least one serial clock after every byte. With frame hold on, it stays active from byte to byte and goes inactive only after a byte tagged end-of-message.

Sequencer states: IDLE (no frame, buffer watched), LOW (serial clock low, lanes driven), HIGH (serial clock high, after the sampling edge), HOLD (frame kept active while waiting for the next byte) and GAP (frame select inactive for one serial clock). The state transitions are: IDLE to LOW on a pop; LOW to HIGH always; HIGH to LOW while steps remain, or on a back-to-back pop under hold; HIGH to HOLD under hold when the buffer is empty; HIGH to GAP otherwise; HOLD to LOW on a pop; HOLD to GAP when hold is released; GAP to IDLE after two cycles.

Top module: `multilane_spi_master`

## Requirements
- R1: Mode codes are 0 legacy, 1 write-only, 2 read/write, 3 two-lane read, 4 two-lane write, 5 four-lane read and 6 four-lane write. Code 7 is never accepted. After reset the mode is 0 and `mode_q` shows the current mode one cycle after an accepted write.
- R2: Allowed transitions: from 0 to 0, 1 or 2; from 1 or 2 to any of 0..6; from 3 or 4 to 1, 2, 3 or 4; from 5 or 6 to 1, 2, 5 or 6. Any other request leaves `mode_q` unchanged and sets `illegal_flag`.
- R3: A transition that enters or leaves mode 0 is rejected, as an illegal request, while the transmit buffer holds any entry.
- R4: `illegal_flag` stays set until `illegal_clr` is pulsed. If a rejected request and a clear arrive in the same cycle, the flag is set.
- R5: Each byte goes out using the mode that was current when it was pushed, even if the mode changes while the byte waits in the buffer.
- R6: In modes 0, 1 and 2, a byte shifts out MSB first on `lane_out[0]` over 8 serial clocks with `lane_oe` = 0001. In modes 0 and 2 the received byte is sampled from `lane_in[1]`, MSB first.
- R7: In mode 1, and in modes 4 and 6, no received byte is delivered and `rx_valid` stays low.
- R8: Two-lane modes move 2 bits per serial clock over 4 clocks, with the higher bit on lane 1. Mode 4 drives with `lane_oe` = 0011; mode 3 releases all lanes (`lane_oe` = 0000) and samples `lane_in[1:0]`.
- R9: Four-lane modes move the upper nibble first and the lower nibble second, with bit 3 of each nibble on lane 3. Mode 6 drives with `lane_oe` = 1111; mode 5 releases all lanes and samples `lane_in[3:0]`.
- R10: With `hold_en` low, `cs_n` goes high for at least one serial clock (two system clocks) between any two bytes.
- R11: With `hold_en` high, `cs_n` stays low between bytes, including while the frame waits for the next push. It rises only after a byte pushed with `push_last` = 1.
- R12: Mode 0 timing: `sclk` idles low and rises only while `cs_n` is low. Output data is stable across each rising edge, and input data is sampled on that edge.
- R13: After reset `cs_n` = 1, `sclk` = 0, `lane_oe` = 0, `busy` = 0 and `push_ready` = 1. `push_ready` falls when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Push a byte into the transmit buffer |
| push_data | input | 8 | Byte to send (dummy byte in read modes) |
| push_last | input | 1 | Tags the byte as end of message |
| push_ready | output | 1 | Transmit buffer has room |
| mode_wr | input | 1 | Request a lane mode change |
| mode_req | input | 3 | Requested mode code |
| mode_q | output | 3 | Current lane mode |
| illegal_clr | input | 1 | Clears the illegal-transition flag |
| illegal_flag | output | 1 | Sticky flag for a rejected mode request |
| hold_en | input | 1 | Keep frame select active across a message |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select |
| lane_out | output | 4 | Data lane output values |
| lane_oe | output | 4 | Per-lane output enables |
| lane_in | input | 4 | Data lane input values |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | A byte is buffered or in flight |

## Verification
A mode write shows up on `mode_q` and `illegal_flag` one clock after the request, so the bench reads both on the falling edge that follows the request cycle. Lane data is checked at each rising edge of `sclk`, observed on the falling system edge inside the HIGH phase. The bench drives `lane_in` on the falling edge inside LOW, so the value is stable at the next rising edge, where the design samples it. `rx_valid` arrives one clock after the final HIGH phase of a byte. The bench compares it against a queue that fills when it counts the last rising edge of a reading byte, so ordering rather than a fixed delay ties each received byte to its dummy.

// File: rtl/spi_lane_pkg.sv
package spi_lane_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;

    typedef enum logic [2:0] {
        MD_LEGACY = 3'd0,
        MD_WRITE  = 3'd1,
        MD_RDWR   = 3'd2,
        MD_BI_RD  = 3'd3,
        MD_BI_WR  = 3'd4,
        MD_QD_RD  = 3'd5,
        MD_QD_WR  = 3'd6,
        MD_RSVD   = 3'd7
    } lane_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH,
        SQ_HOLD,
        SQ_GAP
    } sq_state_e;

    typedef struct packed {
        lane_mode_e        mode;
        logic              last;
        logic [BYTE_W-1:0] data;
    } tx_entry_t;

    function automatic logic transition_ok(lane_mode_e from_m, lane_mode_e to_m);
        logic ok;
        case (from_m)
            MD_LEGACY:          ok = to_m inside {MD_LEGACY, MD_WRITE, MD_RDWR};
            MD_WRITE, MD_RDWR:  ok = (to_m != MD_RSVD);
            MD_BI_RD, MD_BI_WR: ok = to_m inside {MD_WRITE, MD_RDWR, MD_BI_RD, MD_BI_WR};
            MD_QD_RD, MD_QD_WR: ok = to_m inside {MD_WRITE, MD_RDWR, MD_QD_RD, MD_QD_WR};
            default:            ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic mode_reads(lane_mode_e m);
        return m inside {MD_LEGACY, MD_RDWR, MD_BI_RD, MD_QD_RD};
    endfunction

    function automatic logic [LANES-1:0] drive_mask(lane_mode_e m);
        logic [LANES-1:0] msk;
        case (m)
            MD_LEGACY, MD_WRITE, MD_RDWR: msk = 4'b0001;
            MD_BI_WR:                     msk = 4'b0011;
            MD_QD_WR:                     msk = 4'b1111;
            default:                      msk = 4'b0000;
        endcase
        return msk;
    endfunction

    function automatic logic [2:0] final_step(lane_mode_e m);
        logic [2:0] s;
        case (m)
            MD_BI_RD, MD_BI_WR: s = 3'd3;
            MD_QD_RD, MD_QD_WR: s = 3'd1;
            default:            s = 3'd7;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lane_mode_ctrl.sv
module lane_mode_ctrl
    import spi_lane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_req,
    input  logic       illegal_clr,
    input  logic       tx_empty,
    output lane_mode_e mode_q,
    output logic       illegal_flag
);

    lane_mode_e req_m;
    logic       crosses_legacy;
    logic       accept;

    always_comb begin
        req_m          = lane_mode_e'(mode_req);
        crosses_legacy = (mode_q == MD_LEGACY) != (req_m == MD_LEGACY);
        accept         = transition_ok(mode_q, req_m) && (!crosses_legacy || tx_empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= MD_LEGACY;
            illegal_flag <= 1'b0;
        end else begin
            if (mode_wr && accept) begin
                mode_q <= req_m;
            end
            if (mode_wr && !accept) begin
                illegal_flag <= 1'b1;
            end else if (illegal_clr) begin
                illegal_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tagged_tx_fifo.sv
module tagged_tx_fifo
    import spi_lane_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  tx_entry_t wr_entry,
    input  logic      rd_en,
    output tx_entry_t rd_entry,
    output logic      empty,
    output logic      full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_entry_t       store [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign rd_entry = store[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en && !full) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en && !empty) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CW'(wr_en && !full) - CW'(rd_en && !empty);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            store[wr_ptr] <= wr_entry;
        end
    end

endmodule

// File: rtl/lane_sequencer.sv
module lane_sequencer
    import spi_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_en,
    input  tx_entry_t         head,
    input  logic              fifo_empty,
    output logic              pop,
    input  logic [LANES-1:0]  lane_in,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  lane_out,
    output logic [LANES-1:0]  lane_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              active,
    output lane_mode_e        cur_mode
);

    sq_state_e         state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rxsh;
    logic [2:0]        step;
    logic              cur_last;
    logic              gap_cnt;
    logic              in_frame;
    logic [LANES-1:0]  raw_out;

    // next-state and pop decision
    always_comb begin
        nxt = state;
        pop = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (!fifo_empty) begin
                    pop = 1'b1;
                    nxt = SQ_LOW;
                end
            end
            SQ_LOW: nxt = SQ_HIGH;
            SQ_HIGH: begin
                if (step != 3'd0) begin
                    nxt = SQ_LOW;
                end else if (hold_en && !cur_last) begin
                    if (!fifo_empty) begin
                        pop = 1'b1;
                        nxt = SQ_LOW;
                    end else begin
                        nxt = SQ_HOLD;
                    end
                end else begin
                    nxt = SQ_GAP;
                end
            end
            SQ_HOLD: begin
                if (!fifo_empty) begin
                    pop = 1'b1;
                    nxt = SQ_LOW;
                end else if (!hold_en) begin
                    nxt = SQ_GAP;
                end
            end
            SQ_GAP: begin
                if (gap_cnt) nxt = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            rxsh     <= '0;
            step     <= '0;
            cur_mode <= MD_LEGACY;
            cur_last <= 1'b0;
            gap_cnt  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            gap_cnt  <= (state == SQ_GAP);
            if (pop) begin
                shreg    <= head.data;
                cur_mode <= head.mode;
                cur_last <= head.last;
                step     <= final_step(head.mode);
            end else if (state == SQ_HIGH && step != 3'd0) begin
                step <= step - 3'd1;
                case (cur_mode)
                    MD_BI_RD, MD_BI_WR: shreg <= {shreg[5:0], 2'b00};
                    MD_QD_RD, MD_QD_WR: shreg <= {shreg[3:0], 4'b0000};
                    default:            shreg <= {shreg[6:0], 1'b0};
                endcase
            end
            if (state == SQ_LOW) begin
                case (cur_mode)
                    MD_BI_RD, MD_BI_WR: rxsh <= {rxsh[5:0], lane_in[1:0]};
                    MD_QD_RD, MD_QD_WR: rxsh <= {rxsh[3:0], lane_in[3:0]};
                    default:            rxsh <= {rxsh[6:0], lane_in[1]};
                endcase
            end
            if (state == SQ_HIGH && step == 3'd0 && mode_reads(cur_mode)) begin
                rx_valid <= 1'b1;
                rx_data  <= rxsh;
            end
        end
    end

    // outputs
    always_comb begin
        in_frame = (state == SQ_LOW) || (state == SQ_HIGH);
        sclk     = (state == SQ_HIGH);
        cs_n     = !(in_frame || state == SQ_HOLD);
        active   = (state != SQ_IDLE);
        case (cur_mode)
            MD_BI_RD, MD_BI_WR: raw_out = {2'b00, shreg[7:6]};
            MD_QD_RD, MD_QD_WR: raw_out = shreg[7:4];
            default:            raw_out = {3'b000, shreg[7]};
        endcase
        lane_oe  = in_frame ? drive_mask(cur_mode) : '0;
        lane_out = raw_out & lane_oe;
    end

endmodule

// File: rtl/multilane_spi_master.sv
module multilane_spi_master
    import spi_lane_pkg::*;
#(
    parameter int TX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    input  logic       push_last,
    output logic       push_ready,
    input  logic       mode_wr,
    input  logic [2:0] mode_req,
    output logic [2:0] mode_q,
    input  logic       illegal_clr,
    output logic       illegal_flag,
    input  logic       hold_en,
    output logic       sclk,
    output logic       cs_n,
    output logic [3:0] lane_out,
    output logic [3:0] lane_oe,
    input  logic [3:0] lane_in,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       busy
);

    lane_mode_e mode_cur;
    lane_mode_e seq_mode_e;
    logic [2:0] seq_mode;
    tx_entry_t  new_entry;
    tx_entry_t  head;
    logic       fifo_empty;
    logic       fifo_full;
    logic       pop;
    logic       seq_active;

    assign new_entry  = '{mode: mode_cur, last: push_last, data: push_data};
    assign push_ready = !fifo_full;
    assign mode_q     = mode_cur;
    assign seq_mode   = seq_mode_e;
    assign busy       = seq_active || !fifo_empty;

    lane_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_req     (mode_req),
        .illegal_clr  (illegal_clr),
        .tx_empty     (fifo_empty),
        .mode_q       (mode_cur),
        .illegal_flag (illegal_flag)
    );

    tagged_tx_fifo #(.DEPTH(TX_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_valid),
        .wr_entry (new_entry),
        .rd_en    (pop),
        .rd_entry (head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    lane_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_en    (hold_en),
        .head       (head),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .lane_in    (lane_in),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .lane_out   (lane_out),
        .lane_oe    (lane_oe),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .active     (seq_active),
        .cur_mode   (seq_mode_e)
    );

endmodule

// File: rtl/spi_lane_checker.sv
module spi_lane_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sclk,
    input logic       cs_n,
    input logic [3:0] lane_oe,
    input logic       rx_valid,
    input logic [2:0] mode_q,
    input logic       illegal_flag,
    input logic       tx_empty,
    input logic [2:0] seq_mode
);

    AST_SCLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n); // R12

    AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_flag) |-> (mode_q == $past(mode_q))); // R2

    AST_LEGACY_SWAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q != $past(mode_q)) && ((mode_q == 3'd0) || ($past(mode_q) == 3'd0)))
            |-> $past(tx_empty)); // R3

    AST_RX_ONLY_READ_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(seq_mode) inside {3'd0, 3'd2, 3'd3, 3'd5})); // R7

    AST_READ_LANES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (seq_mode inside {3'd3, 3'd5})) |-> (lane_oe == 4'b0000)); // R8

    AST_MODE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 3'd7); // R1

endmodule

bind multilane_spi_master spi_lane_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .lane_oe      (lane_oe),
    .rx_valid     (rx_valid),
    .mode_q       (mode_q),
    .illegal_flag (illegal_flag),
    .tx_empty     (fifo_empty),
    .seq_mode     (seq_mode)
);

// File: tb/tb_multilane_spi_master.sv
module tb_multilane_spi_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_last = 1'b0;
    logic       push_ready;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_req = '0;
    logic [2:0] mode_q;
    logic       illegal_clr = 1'b0;
    logic       illegal_flag;
    logic       hold_en = 1'b0;
    logic       sclk, cs_n, rx_valid, busy;
    logic [3:0] lane_out, lane_oe;
    logic [3:0] lane_in = '0;
    logic [7:0] rx_data;

    always #10 clk = ~clk;

    multilane_spi_master dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .push_last(push_last), .push_ready(push_ready), .mode_wr(mode_wr),
        .mode_req(mode_req), .mode_q(mode_q), .illegal_clr(illegal_clr),
        .illegal_flag(illegal_flag), .hold_en(hold_en), .sclk(sclk), .cs_n(cs_n),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent model of the mode rules
    int m_mode = 0;
    bit m_flag = 0;

    function automatic bit b_legal(int f, int t, bit empty);
        bit ok;
        if (t == 7) return 0;
        case (f)
            0:       ok = (t <= 2);
            1, 2:    ok = 1;
            3, 4:    ok = (t >= 1 && t <= 4);
            default: ok = (t == 1 || t == 2 || t == 5 || t == 6);
        endcase
        if (((f == 0) != (t == 0)) && !empty) ok = 0;
        return ok;
    endfunction

    function automatic int b_width(int m);
        if (m == 3 || m == 4) return 2;
        if (m == 5 || m == 6) return 4;
        return 1;
    endfunction

    function automatic int b_mask(int m);
        case (m)
            0, 1, 2: return 1;
            4:       return 3;
            6:       return 15;
            default: return 0;
        endcase
    endfunction

    function automatic bit b_reads(int m);
        return (m == 0 || m == 2 || m == 3 || m == 5);
    endfunction

    // expected byte queue
    int exp_data [0:511];
    int exp_mode [0:511];
    bit exp_last [0:511];
    bit exp_hold [0:511];
    int eh = 0, et = 0;
    int rxq [0:511];
    int rh = 0, rt = 0;

    task automatic push_byte(input int d, input bit last);
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        push_valid = 1'b1;
        push_data  = d[7:0];
        push_last  = last;
        exp_data[et] = d & 8'hFF;
        exp_mode[et] = m_mode;
        exp_last[et] = last;
        exp_hold[et] = hold_en;
        et++;
        @(negedge clk);
        push_valid = 1'b0;
        push_last  = 1'b0;
    endtask

    task automatic write_mode(input int code, input bit empty);
        @(negedge clk);
        mode_wr  = 1'b1;
        mode_req = code[2:0];
        @(negedge clk);
        mode_wr  = 1'b0;
        if (b_legal(m_mode, code, empty)) m_mode = code;
        else m_flag = 1;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        illegal_clr = 1'b1;
        @(negedge clk);
        illegal_clr = 1'b0;
        m_flag = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!busy && cs_n) quiet++;
            else quiet = 0;
        end
        chk(eh == et, "R5 all pushed bytes sent", eh, et);
        chk(rh == rt, "R6 all reads delivered", rh, rt);
    endtask

    // serial monitor and lane model
    logic prev_sclk = 1'b0;
    bit   saw_gap = 0;
    bit   exp_gap = 0;
    bit   have_prev = 0;
    int   step_i = 0;
    int   cap = 0;

    always @(negedge clk) begin
        int m, w, r, chunk;
        if (rst_n) begin
            if (cs_n) saw_gap = 1;
            if (sclk && !prev_sclk) begin
                if (eh == et) begin
                    chk(0, "R12 serial clock with no byte queued", 1, 0);
                end else begin
                    m = exp_mode[eh];
                    w = b_width(m);
                    if (step_i == 0 && have_prev) begin
                        if (exp_gap) chk(saw_gap == exp_gap, "R10 frame gap", saw_gap, exp_gap);
                        else         chk(saw_gap == exp_gap, "R11 frame held", saw_gap, exp_gap);
                    end
                    if (w == 1)      chk(lane_oe == b_mask(m), "R6 lane enables", lane_oe, b_mask(m));
                    else if (w == 2) chk(lane_oe == b_mask(m), "R8 lane enables", lane_oe, b_mask(m));
                    else             chk(lane_oe == b_mask(m), "R9 lane enables", lane_oe, b_mask(m));
                    cap = (cap << w) | (lane_out & ((1 << w) - 1));
                    step_i++;
                    if (step_i * w == 8) begin
                        if (b_mask(m) != 0)
                            chk((cap & 8'hFF) == exp_data[eh], "R5 byte on lanes", cap & 8'hFF, exp_data[eh]);
                        if (b_reads(m)) begin
                            rxq[rt] = exp_data[eh] ^ 8'h3C;
                            rt++;
                        end
                        exp_gap   = !(exp_hold[eh] && !exp_last[eh]);
                        have_prev = 1;
                        saw_gap   = 0;
                        eh++;
                        step_i = 0;
                        cap    = 0;
                    end
                end
            end
            if (!sclk && !cs_n && eh != et) begin
                w = b_width(exp_mode[eh]);
                r = exp_data[eh] ^ 8'h3C;
                chunk = (r >> (8 - w * (step_i + 1))) & ((1 << w) - 1);
                if (w == 1) lane_in = {2'b00, chunk[0], 1'b0};
                else        lane_in = chunk[3:0];
            end
            if (rx_valid) begin
                if (rh == rt) begin
                    chk(0, "R7 unexpected received byte", rx_data, 0);
                end else begin
                    chk(rx_data == rxq[rh][7:0], "R6 received byte", rx_data, rxq[rh]);
                    rh++;
                end
            end
            prev_sclk = sclk;
        end
    end

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 / R1 reset state
        chk(cs_n == 1'b1, "R13 cs_n at reset", cs_n, 1);
        chk(sclk == 1'b0, "R12 sclk idles low", sclk, 0);
        chk(lane_oe == 4'b0, "R13 lanes released", lane_oe, 0);
        chk(busy == 1'b0, "R13 busy at reset", busy, 0);
        chk(push_ready == 1'b1, "R13 push_ready at reset", push_ready, 1);
        chk(mode_q == 3'd0, "R1 reset mode", mode_q, 0);
        chk(illegal_flag == 1'b0, "R4 flag at reset", illegal_flag, 0);

        // R2 / R4 exhaustive transition sweep with empty buffer
        for (int f = 0; f < 7; f++) begin
            for (int t = 0; t < 8; t++) begin
                write_mode(2, 1);
                write_mode(f, 1);
                clear_flag();
                write_mode(t, 1);
                chk(mode_q == m_mode, "R2 mode after request", mode_q, m_mode);
                chk(illegal_flag == m_flag, "R2 illegal flag", illegal_flag, m_flag);
                if (m_flag) begin
                    write_mode(2, 1);
                    chk(illegal_flag == 1'b1, "R4 flag sticky", illegal_flag, 1);
                end
                clear_flag();
                chk(illegal_flag == 1'b0, "R4 flag cleared", illegal_flag, 0);
            end
        end

        // R4 set wins over clear in the same cycle
        write_mode(0, 1);
        @(negedge clk);
        mode_wr = 1'b1; mode_req = 3'd5; illegal_clr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; illegal_clr = 1'b0;
        chk(illegal_flag == 1'b1, "R4 set beats clear", illegal_flag, 1);
        chk(mode_q == 3'd0, "R2 rejected request keeps mode", mode_q, 0);
        clear_flag();

        // R6 R7 R8 R9 R10: every mode, several byte patterns, no hold
        for (int m = 0; m < 7; m++) begin
            write_mode(2, 1);
            write_mode(m, 1);
            for (int k = 0; k < 3; k++) push_byte((k * 77 + m * 29 + 8'h5A) & 8'hFF, 1'b0);
            wait_idle();
        end

        // R11 frame hold: messages in several modes
        hold_en = 1'b1;
        for (int m = 2; m < 7; m++) begin
            write_mode(2, 1);
            write_mode(m, 1);
            push_byte(8'hC3 ^ m, 1'b0);
            push_byte(8'h96 + m, 1'b0);
            push_byte(8'h0F << m, 1'b1);
            wait_idle();
        end
        // R11 frame stays active while waiting for the next byte
        write_mode(6, 1);
        push_byte(8'hE7, 1'b0);
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b0, "R11 held while buffer empty", cs_n, 0);
        push_byte(8'h18, 1'b1);
        wait_idle();
        chk(cs_n == 1'b1, "R11 released after last byte", cs_n, 1);
        hold_en = 1'b0;

        // R5 per-byte tags and R3 legacy swap needs empty buffer
        write_mode(2, 1);
        push_byte(8'h81, 1'b0);
        push_byte(8'h42, 1'b0);
        push_byte(8'h24, 1'b0);
        write_mode(6, 0);
        chk(mode_q == 3'd6, "R5 mode change while buffered", mode_q, 6);
        push_byte(8'hB5, 1'b0);
        write_mode(2, 0);
        write_mode(0, 0);
        chk(mode_q == 3'd2, "R3 legacy entry blocked", mode_q, 2);
        chk(illegal_flag == 1'b1, "R3 blocked entry flagged", illegal_flag, 1);
        wait_idle();
        clear_flag();
        write_mode(0, 1);
        chk(mode_q == 3'd0, "R3 legacy entry when empty", mode_q, 0);
        chk(illegal_flag == 1'b0, "R3 no flag when empty", illegal_flag, 0);

        // R13 buffer full
        write_mode(1, 1);
        for (int k = 0; k < 5; k++) push_byte(8'h30 + k, 1'b0);
        chk(push_ready == 1'b0, "R13 push_ready low when full", push_ready, 0);
        wait_idle();
        chk(push_ready == 1'b1, "R13 push_ready after drain", push_ready, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule